// File: doc/BRIEF.md
# Lower-Level Instruction Trap Checker

This block takes one instruction at a time that is being executed below the monitor level. It decides whether the instruction runs normally, is undefined, or traps to the monitor (level 3). It covers five instruction classes:

- the hypervisor call and the secure monitor call, each gated by its own enable or disable bit;
- wait-for-event and wait-for-interrupt, each with its own trap bit, qualified by low-power intent, condition pass and earlier traps;
- accesses from secure level 1 to the secure physical timer registers.

Instruction decode happens upstream. The exception entry sequence happens downstream.

The caller presents the following with a one-cycle valid strobe:

- the instruction class;
- the current exception level, the security state and the 32/64-bit state;
- the condition-code qualifiers;
- a would-enter-low-power flag;
- a flag saying that a trap control at a lower level already claimed the instruction;
- the relevant configuration bits.

One clock later a registered 2-bit verdict appears with a valid pulse. The verdict holds between strobes.

Top module: `trap_verdict`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and verdict_o is 2'b00.
- R2: valid_o is 1 exactly in the cycle after a cycle with valid_i high. verdict_o changes only after a strobe, and holds its value otherwise.
- R3: Verdict codes are 2'b00 execute, 2'b01 undefined and 2'b10 trap to monitor. 2'b11 never appears. Class codes are 0 hypervisor call, 1 monitor call, 2 wait-for-event, 3 wait-for-interrupt and 4 secure timer access. Codes 5 to 7 always execute. Undefined outranks trap.
- R4: A hypervisor call with hvc_en_i = 0 is undefined at every level.
- R5: When hvc_en_i = 1, a hypervisor call is undefined at level 0, and at secure (nonsec_i = 0) level 1 when sel2_en_i = 0. It executes at levels 1 to 3 otherwise.
- R6: A monitor call is undefined at level 0 in all cases. It is also undefined at any level when smc_dis_i = 1. Otherwise it executes.
- R7: A wait-for-event (wait-for-interrupt) at levels 0 to 2 traps when wfe_trap_i (wfi_trap_i) is 1 and low_power_i is 1. If either is 0, it executes.
- R8: When lower_trap_i = 1, none of classes 2, 3 and 4 traps to the monitor. The verdict is execute.
- R9: In 32-bit state (is64_i = 0), a conditional wait (cond_i = 1) that fails its check (cond_pass_i = 0) does not trap. In 64-bit state the condition flags are ignored.
- R10: A secure timer access traps when all of the following hold: level 1, nonsec_i = 0, is64_i = 1, st_open_i = 0 and sel2_en_i = 0. Otherwise it executes.
- R11: With sel2_en_i = 1, a secure timer access never traps, whatever the value of st_open_i.
- R12: At level 3, classes 2, 3 and 4 always execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| cls_i | input | 3 | Instruction class code |
| lvl_i | input | 2 | Current exception level |
| nonsec_i | input | 1 | 1 = non-secure state |
| is64_i | input | 1 | 1 = 64-bit execution state |
| cond_i | input | 1 | Instruction is conditional |
| cond_pass_i | input | 1 | Condition check passed |
| low_power_i | input | 1 | Instruction would enter low power |
| lower_trap_i | input | 1 | A lower-level trap already claimed it |
| hvc_en_i | input | 1 | Hypervisor call enable |
| smc_dis_i | input | 1 | Monitor call disable |
| wfe_trap_i | input | 1 | Wait-for-event trap enable |
| wfi_trap_i | input | 1 | Wait-for-interrupt trap enable |
| st_open_i | input | 1 | 1 = secure timer accesses not trapped |
| sel2_en_i | input | 1 | Secure level 2 enabled |
| valid_o | output | 1 | Verdict valid, one cycle after valid_i |
| verdict_o | output | 2 | 00 execute, 01 undefined, 10 trap |

## Verification
The only state is the verdict register and the valid flag, so a fault shows on the cycle right after the strobe concerned. Examples are a wrong qualifier in a gate, a swapped priority, or a register that loads without a strobe. Each can show as a wrong code, a missing valid pulse, or a verdict that drifts between strobes. The bench's reference model compares both outputs on every clock. Directed cases reach the narrow timer and condition-code corners. A long stream of biased random inputs covers the rest.

// File: rtl/trap_verdict_pkg.sv
package trap_verdict_pkg;
  localparam int CLS_W  = 3;
  localparam int LVL_W  = 2;
  localparam int VERD_W = 2;
  localparam int N_WAIT = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_HVC  = 3'd0,
    CLS_SMC  = 3'd1,
    CLS_WFE  = 3'd2,
    CLS_WFI  = 3'd3,
    CLS_STMR = 3'd4
  } cls_e;

  typedef enum logic [VERD_W-1:0] {
    V_EXEC  = 2'b00,
    V_UNDEF = 2'b01,
    V_TRAP  = 2'b10
  } verdict_e;

  localparam logic [LVL_W-1:0] LVL_USR = 2'd0;
  localparam logic [LVL_W-1:0] LVL_KRN = 2'd1;
  localparam logic [LVL_W-1:0] LVL_MON = 2'd3;
endpackage

// File: rtl/tv_call_gate.sv
module tv_call_gate
  import trap_verdict_pkg::*;
(
  input  logic             is_hvc_i,
  input  logic             is_smc_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             nonsec_i,
  input  logic             sel2_en_i,
  input  logic             hvc_en_i,
  input  logic             smc_dis_i,
  output logic             undef_o
);
  logic at_usr, sec_krn_no_l2, hvc_undef, smc_undef;

  always_comb begin
    at_usr        = (lvl_i == LVL_USR);
    sec_krn_no_l2 = (lvl_i == LVL_KRN) && !nonsec_i && !sel2_en_i;
    hvc_undef     = !hvc_en_i || at_usr || sec_krn_no_l2;
    smc_undef     = smc_dis_i || at_usr;
    undef_o       = (is_hvc_i && hvc_undef) || (is_smc_i && smc_undef);
  end
endmodule

// File: rtl/tv_wait_trap.sv
module tv_wait_trap (
  input  logic hit_i,
  input  logic trap_en_i,
  input  logic below_mon_i,
  input  logic low_power_i,
  input  logic lower_trap_i,
  input  logic is64_i,
  input  logic cond_i,
  input  logic cond_pass_i,
  output logic trap_o
);
  logic cond_ok;

  always_comb begin
    // condition flags only qualify 32-bit conditional forms
    cond_ok = is64_i || !cond_i || cond_pass_i;
    trap_o  = hit_i && trap_en_i && below_mon_i && low_power_i &&
              !lower_trap_i && cond_ok;
  end
endmodule

// File: rtl/tv_timer_gate.sv
module tv_timer_gate
  import trap_verdict_pkg::*;
(
  input  logic             hit_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             nonsec_i,
  input  logic             is64_i,
  input  logic             st_open_i,
  input  logic             sel2_en_i,
  input  logic             lower_trap_i,
  output logic             trap_o
);
  logic eff_open;

  always_comb begin
    eff_open = st_open_i || sel2_en_i;
    trap_o   = hit_i && !eff_open && (lvl_i == LVL_KRN) && !nonsec_i &&
               is64_i && !lower_trap_i;
  end
endmodule

// File: rtl/trap_verdict.sv
module trap_verdict
  import trap_verdict_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               valid_i,
  input  logic [trap_verdict_pkg::CLS_W-1:0] cls_i,
  input  logic [trap_verdict_pkg::LVL_W-1:0] lvl_i,
  input  logic                               nonsec_i,
  input  logic                               is64_i,
  input  logic                               cond_i,
  input  logic                               cond_pass_i,
  input  logic                               low_power_i,
  input  logic                               lower_trap_i,
  input  logic                               hvc_en_i,
  input  logic                               smc_dis_i,
  input  logic                               wfe_trap_i,
  input  logic                               wfi_trap_i,
  input  logic                               st_open_i,
  input  logic                               sel2_en_i,
  output logic                               valid_o,
  output logic [trap_verdict_pkg::VERD_W-1:0] verdict_o
);
  logic              below_mon;
  logic              undef, timer_trap, any_trap;
  logic [N_WAIT-1:0] wait_hit, wait_en, wait_trap;
  verdict_e          nxt;

  assign below_mon = (lvl_i != LVL_MON);
  assign wait_hit  = {cls_i == CLS_WFI, cls_i == CLS_WFE};
  assign wait_en   = {wfi_trap_i, wfe_trap_i};

  tv_call_gate u_call (
    .is_hvc_i (cls_i == CLS_HVC),
    .is_smc_i (cls_i == CLS_SMC),
    .lvl_i    (lvl_i),
    .nonsec_i (nonsec_i),
    .sel2_en_i(sel2_en_i),
    .hvc_en_i (hvc_en_i),
    .smc_dis_i(smc_dis_i),
    .undef_o  (undef)
  );

  for (genvar g = 0; g < N_WAIT; g++) begin : g_wait
    tv_wait_trap u_wait (
      .hit_i       (wait_hit[g]),
      .trap_en_i   (wait_en[g]),
      .below_mon_i (below_mon),
      .low_power_i (low_power_i),
      .lower_trap_i(lower_trap_i),
      .is64_i      (is64_i),
      .cond_i      (cond_i),
      .cond_pass_i (cond_pass_i),
      .trap_o      (wait_trap[g])
    );
  end

  tv_timer_gate u_timer (
    .hit_i       (cls_i == CLS_STMR),
    .lvl_i       (lvl_i),
    .nonsec_i    (nonsec_i),
    .is64_i      (is64_i),
    .st_open_i   (st_open_i),
    .sel2_en_i   (sel2_en_i),
    .lower_trap_i(lower_trap_i),
    .trap_o      (timer_trap)
  );

  assign any_trap = (|wait_trap) || timer_trap;

  always_comb begin
    if (undef)         nxt = V_UNDEF;
    else if (any_trap) nxt = V_TRAP;
    else               nxt = V_EXEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      verdict_o <= V_EXEC;
    end else begin
      valid_o <= valid_i;
      if (valid_i) verdict_o <= nxt;
    end
  end
endmodule

// File: rtl/trap_verdict_chk.sv
module trap_verdict_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [2:0] cls_i,
  input logic [1:0] lvl_i,
  input logic       lower_trap_i,
  input logic       hvc_en_i,
  input logic       smc_dis_i,
  input logic       sel2_en_i,
  input logic       valid_o,
  input logic [1:0] verdict_o
);
  logic waitcls;
  assign waitcls = (cls_i == 3'd2) || (cls_i == 3'd3) || (cls_i == 3'd4);

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(verdict_o));
  a_r3_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o != 2'b11);
  a_r4_hvc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 3'd0 && !hvc_en_i) |=> verdict_o == 2'b01);
  a_r6_smc_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 3'd1 && (lvl_i == 2'd0 || smc_dis_i)) |=> verdict_o == 2'b01);
  a_r8_lower_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && waitcls && lower_trap_i) |=> verdict_o == 2'b00);
  a_r11_sel2_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 3'd4 && sel2_en_i) |=> verdict_o == 2'b00);
  a_r12_mon_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && waitcls && lvl_i == 2'd3) |=> verdict_o == 2'b00);
endmodule

bind trap_verdict trap_verdict_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cls_i(cls_i),
  .lvl_i(lvl_i), .lower_trap_i(lower_trap_i), .hvc_en_i(hvc_en_i),
  .smc_dis_i(smc_dis_i), .sel2_en_i(sel2_en_i), .valid_o(valid_o),
  .verdict_o(verdict_o)
);

// File: tb/trap_verdict_test.sv
module trap_verdict_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 0, nonsec_i = 0, is64_i = 0, cond_i = 0, cond_pass_i = 0;
  logic low_power_i = 0, lower_trap_i = 0, hvc_en_i = 0, smc_dis_i = 0;
  logic wfe_trap_i = 0, wfi_trap_i = 0, st_open_i = 0, sel2_en_i = 0;
  logic [2:0] cls_i = 0;
  logic [1:0] lvl_i = 0;
  logic       valid_o;
  logic [1:0] verdict_o;

  int tests = 0, fails = 0;
  logic [1:0] exp_v = 2'b00;
  logic       exp_vld = 1'b0;
  string      exp_tag = "R1";
  bit         done = 0;

  always #5 clk = ~clk;

  trap_verdict uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .cls_i(cls_i), .lvl_i(lvl_i),
    .nonsec_i(nonsec_i), .is64_i(is64_i), .cond_i(cond_i), .cond_pass_i(cond_pass_i),
    .low_power_i(low_power_i), .lower_trap_i(lower_trap_i), .hvc_en_i(hvc_en_i),
    .smc_dis_i(smc_dis_i), .wfe_trap_i(wfe_trap_i), .wfi_trap_i(wfi_trap_i),
    .st_open_i(st_open_i), .sel2_en_i(sel2_en_i), .valid_o(valid_o), .verdict_o(verdict_o)
  );

  function automatic logic [1:0] ref_v(input logic [2:0] c, input logic [1:0] l,
      input logic ns, s64, cnd, cp, lp, lt, he, sd, we, wi, st, s2, output string tag);
    logic en;
    tag = "R3";
    case (c)
      3'd0: begin
        if (!he) begin tag = "R4"; return 2'b01; end
        tag = "R5";
        if (l == 0 || (l == 1 && !ns && !s2)) return 2'b01;
        return 2'b00;
      end
      3'd1: begin tag = "R6"; return (l == 0 || sd) ? 2'b01 : 2'b00; end
      3'd2, 3'd3: begin
        en = (c == 3'd2) ? we : wi;
        if (l == 3) begin tag = "R12"; return 2'b00; end
        tag = "R7";
        if (!en || !lp) return 2'b00;
        if (lt) begin tag = "R8"; return 2'b00; end
        if (!s64 && cnd && !cp) begin tag = "R9"; return 2'b00; end
        return 2'b10;
      end
      3'd4: begin
        if (l == 3) begin tag = "R12"; return 2'b00; end
        if (lt) begin tag = "R8"; return 2'b00; end
        if (s2) begin tag = "R11"; return 2'b00; end
        tag = "R10";
        if (!st && l == 1 && !ns && s64) return 2'b10;
        return 2'b00;
      end
      default: return 2'b00;
    endcase
  endfunction

  task automatic check_outputs();
    tests++;
    if (valid_o !== exp_vld) begin
      fails++;
      $display("FAIL R2 valid_o actual=%b expected=%b", valid_o, exp_vld);
    end
    tests++;
    if (verdict_o !== exp_v) begin
      fails++;
      $display("FAIL %s verdict_o actual=%b expected=%b", exp_vld ? exp_tag : "R2",
               verdict_o, exp_v);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic [1:0] l,
      input logic ns, s64, cnd, cp, lp, lt, he, sd, we, wi, st, s2);
    string t;
    logic [1:0] r;
    @(negedge clk);
    check_outputs();
    valid_i = v; cls_i = c; lvl_i = l; nonsec_i = ns; is64_i = s64; cond_i = cnd;
    cond_pass_i = cp; low_power_i = lp; lower_trap_i = lt; hvc_en_i = he;
    smc_dis_i = sd; wfe_trap_i = we; wfi_trap_i = wi; st_open_i = st; sel2_en_i = s2;
    exp_vld = v;
    r = ref_v(c, l, ns, s64, cnd, cp, lp, lt, he, sd, we, wi, st, s2, t);
    if (v) begin exp_v = r; exp_tag = t; end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    // R1 reset state
    repeat (3) @(negedge clk);
    check_outputs();
    rst_ni = 1'b1;
    //    v  c  l  ns 64 cd cp lp lt he sd we wi st s2
    step(1, 0, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R4 hvc disabled
    step(1, 0, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0); // R5 secure L1, no L2
    step(1, 0, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1); // R5 secure L1 with L2
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1); // R5 level 0
    step(1, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R6 level 0
    step(1, 1, 3, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0); // R6 disabled
    step(1, 1, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R6 enabled
    step(0, 1, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0); // R2 hold
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R2 hold
    step(1, 2, 0, 1, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0); // R7 wfe trap
    step(1, 3, 2, 1, 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0); // R7 wfi trap
    step(1, 3, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); // R7 no low power
    step(1, 2, 1, 1, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0); // R8 lower claimed
    step(1, 3, 1, 1, 0, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0); // R9 cond fail 32-bit
    step(1, 3, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0, 0); // R9 cond pass 32-bit
    step(1, 2, 1, 1, 1, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0); // R9 64-bit ignores cond
    step(1, 4, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R10 timer trap
    step(1, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R10 32-bit no trap
    step(1, 4, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); // R11 L2 enabled
    step(1, 2, 3, 1, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0); // R12 level 3
    step(1, 6, 1, 0, 1, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0); // R3 other class
    step(1, 0, 1, 0, 1, 0, 0, 1, 0, 0, 1, 1, 1, 0, 0); // R3 undef code
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1;
      logic [31:0] r2;
      r1 = $urandom;
      r2 = $urandom;
      step(r1[0] | r1[1], (r1[4:2] > 3'd5) ? {1'b0, r1[6:5]} : r1[4:2], r1[8:7],
           r1[9], r1[10], r1[11], r1[12], r1[13] | r1[14], r1[15] & r1[16],
           r1[17] | r1[18], r1[19] & r1[20], r1[21], r1[22], r2[0], r2[1] & r2[2]);
      if (r2[7:3] == 5'd0) begin
        rst_ni = 1'b0;
        exp_vld = 1'b0; exp_v = 2'b00;
        @(negedge clk);
        check_outputs(); // R1 mid-run reset
        valid_i = 1'b0;
        rst_ni = 1'b1;
      end
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule